// File: doc/BRIEF.md
# NAND Initial Bad-Block Scanner

After power-up the host pulses `start`. The scanner then visits every erase block of a small-page NAND device, starting at block 0 and moving up to the last block. For each block it asks a lower-level NAND read engine for the factory marker byte, which sits at offset 5 of the 16-byte spare field. It reads that byte from page 0 and, if needed, from page 1. An erased, good location reads FFh. Any other value on either page marks the block as bad.

Each block's verdict goes into a one-bit-per-block table. The host reads the table through a combinational index port. The scanner also keeps a running count of bad blocks. A `done` flag rises once the last block's verdict is stored. The device guarantees block 0 to be good, but the scanner reads it like any other block and raises a warning flag if it turns out bad.

The request port follows valid/ready rules. `req_valid` stays high, with `req_row` and `req_col` held stable, until the engine takes the request with `req_ready`. Only one request is ever outstanding. The response port also follows valid/ready rules. `rsp_ready` is high only while the scanner is waiting for the byte it asked for, and the engine may hold `rsp_valid` high for as long as it needs. A `start` pulse aborts any scan in progress, clears the table, the count and the flags, and begins again at block 0. The engine should only see `start` when it has no request in flight.

Top module: `nand_badblock_scan`

## Requirements
- R1: Requests go out in ascending block order from block 0. Within a block, page 0 is requested before page 1. Each request has `req_row` = block × PAGES + page and `req_col` = 5.
- R2: The table bit for a block is 1 (bad) exactly when the byte returned for page 0 or for page 1 of that block differs from FFh. A value of FFh on every page read gives 0 (good).
- R3: When page 0 of a block returns a value other than FFh, no page-1 request is made for that block. The next request targets page 0 of the next block.
- R4: `bad_count` equals the number of table bits set to 1.
- R5: `done` is low from a `start` until the last block's verdict has been stored. No request is issued while `done` is high, and `done` stays high until the next `start`.
- R6: A `start` pulse clears the table, `bad_count`, `done` and `blk0_warn` on the next clock edge, and restarts the scan at block 0, even when a scan is in progress.
- R7: `blk0_warn` is 1 exactly when block 0 was found bad in the current scan.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_row` and `req_col` hold their values. A new request is issued only after the previous response has been taken.
- R9: After reset, `done`, `bad_count`, `blk0_warn` and `req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that clears the results and starts a scan |
| req_valid | output | 1 | Marker read request is valid |
| req_ready | input | 1 | Read engine accepts the request |
| req_row | output | ROW_W | Row (page) address = block × PAGES + page |
| req_col | output | 4 | Offset within the spare field (always 5) |
| rsp_valid | input | 1 | Response byte is valid |
| rsp_ready | output | 1 | Scanner is waiting for a response |
| rsp_data | input | 8 | Marker byte returned by the engine |
| rd_idx | input | BLK_W | Block index to look up in the table |
| rd_bad | output | 1 | Table bit for `rd_idx` (1 = bad), meaningful while `done` is high |
| bad_count | output | CNT_W | Number of bad blocks found |
| done | output | 1 | The scan has finished |
| blk0_warn | output | 1 | Block 0 was found bad |

## Verification
The bench uses a small configuration of 16 blocks × 4 pages and sweeps the whole table against marker patterns computed arithmetically. The patterns include:
- bad marks on page 0 only, on page 1 only, and on both pages;
- a bad block 0 and a bad last block;
- non-FFh values of several kinds.

A design that ignores page 1 would miss the page-1-only blocks. A design that always reads both pages would show up through the per-run request count and the expected-row check. An off-by-one in the block walk would cause one of three visible faults: a missing last verdict, a `done` that rises early, or a wrong row.

Two further tests target the restart and the interfaces. A restart issued mid-scan, after a full scan that left a bad block 0, must show a zero count and a cleared warning at once, and then the fresh pattern's results. Randomised-looking gaps on `req_ready` and response latency check that requests hold stable under back-pressure and never overlap.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } scan_state_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam int         SPARE_W     = 4;
endpackage

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
  import nbs_pkg::*;
#(
  parameter int NBLK      = 1024,
  parameter int PAGES     = 32,
  parameter int MARK_COL  = 5,
  parameter int ROW_W     = $clog2(NBLK * PAGES),
  parameter int BLK_W     = $clog2(NBLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ROW_W-1:0]   req_row,
  output logic [SPARE_W-1:0] req_col,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [7:0]         rsp_data,
  output logic               wr_en,
  output logic [BLK_W-1:0]   wr_idx,
  output logic               wr_bad,
  output logic               clr,
  output logic               done
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NBLK - 1);

  scan_state_t      state;
  logic [BLK_W-1:0] blk;
  logic             page;
  logic             bad_r;
  logic             mark_bad;

  assign mark_bad = (rsp_data != ERASED_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      blk   <= '0;
      page  <= 1'b0;
      bad_r <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      state <= ST_REQ;
      blk   <= '0;
      page  <= 1'b0;
      bad_r <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (mark_bad || page) begin
            bad_r <= mark_bad;
            state <= ST_WRITE;
          end else begin
            page  <= 1'b1;
            state <= ST_REQ;
          end
        end
        ST_WRITE: begin
          if (blk == LAST_BLK) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else begin
            blk   <= blk + 1'b1;
            page  <= 1'b0;
            state <= ST_REQ;
          end
        end
        default: ;
      endcase
    end
  end

  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_WAIT);
  assign req_row   = ROW_W'(blk) * ROW_W'(PAGES) + ROW_W'(page);
  assign req_col   = SPARE_W'(MARK_COL);
  assign wr_en     = (state == ST_WRITE);
  assign wr_idx    = blk;
  assign wr_bad    = bad_r;
  assign clr       = start;

  // R8: a stalled request keeps its contents
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !start |=> req_valid && $stable(req_row) && $stable(req_col));

  // R3: a bad page-0 mark goes straight to the table write, no second read
  a_r3_skip_page1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && mark_bad && !start |=> wr_en && !req_valid);

  // R5: done holds until a new start
  a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R5: done rises only right after a table write
  a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en));

  // R5: no request while done
  a_r5_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

// File: rtl/nbs_table.sv
module nbs_table #(
  parameter int NBLK  = 1024,
  parameter int BLK_W = $clog2(NBLK),
  parameter int CNT_W = $clog2(NBLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic             wr_bad,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_bad,
  output logic [CNT_W-1:0] bad_count,
  output logic             blk0_warn
);
  logic [NBLK-1:0] bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits      <= '0;
      bad_count <= '0;
      blk0_warn <= 1'b0;
    end else if (clr) begin
      bits      <= '0;
      bad_count <= '0;
      blk0_warn <= 1'b0;
    end else if (wr_en) begin
      bits[wr_idx] <= wr_bad;
      if (wr_bad) begin
        bad_count <= bad_count + 1'b1;
        if (wr_idx == '0) blk0_warn <= 1'b1;
      end
    end
  end

  assign rd_bad = bits[rd_idx];

  // R4: the count moves by at most one per cycle outside a clear
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (bad_count == $past(bad_count)) || (bad_count == $past(bad_count) + 1'b1));

  // R6: a clear empties the count and the warning
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> bad_count == '0 && !blk0_warn);

  // R7: the warning agrees with the block-0 table bit
  a_r7_warn_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    blk0_warn |-> bits[0]);
endmodule

// File: rtl/nand_badblock_scan.sv
module nand_badblock_scan
  import nbs_pkg::*;
#(
  parameter int NBLK     = 1024,
  parameter int PAGES    = 32,
  parameter int MARK_COL = 5,
  parameter int ROW_W    = $clog2(NBLK * PAGES),
  parameter int BLK_W    = $clog2(NBLK),
  parameter int CNT_W    = $clog2(NBLK + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ROW_W-1:0]   req_row,
  output logic [SPARE_W-1:0] req_col,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [7:0]         rsp_data,
  input  logic [BLK_W-1:0]   rd_idx,
  output logic               rd_bad,
  output logic [CNT_W-1:0]   bad_count,
  output logic               done,
  output logic               blk0_warn
);
  logic             wr_en;
  logic [BLK_W-1:0] wr_idx;
  logic             wr_bad;
  logic             clr;

  nbs_ctrl #(
    .NBLK(NBLK), .PAGES(PAGES), .MARK_COL(MARK_COL), .ROW_W(ROW_W), .BLK_W(BLK_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_bad(wr_bad), .clr(clr), .done(done)
  );

  nbs_table #(.NBLK(NBLK), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_bad(wr_bad),
    .rd_idx(rd_idx), .rd_bad(rd_bad), .bad_count(bad_count), .blk0_warn(blk0_warn)
  );
endmodule

// File: tb/nand_badblock_scan_bench.sv
module nand_badblock_scan_bench;
  localparam int NB = 16;
  localparam int PG = 4;
  localparam int RW = $clog2(NB * PG);
  localparam int BW = $clog2(NB);
  localparam int CW = $clog2(NB + 1);

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic          req_valid, req_ready = 0;
  logic [RW-1:0] req_row;
  logic [3:0]    req_col;
  logic          rsp_valid = 0, rsp_ready;
  logic [7:0]    rsp_data = 8'hFF;
  logic [BW-1:0] rd_idx = '0;
  logic          rd_bad;
  logic [CW-1:0] bad_count;
  logic          done, blk0_warn;

  int n_chk = 0, n_fail = 0;
  int cur_pat = 0;
  bit go = 0;
  bit pending = 0, rsp_fire = 0;
  int lat = 0, cyc = 0, nreq = 0;
  int exp_blk = 0, exp_page = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nand_badblock_scan #(.NBLK(NB), .PAGES(PG)) u_nand_badblock_scan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rd_idx(rd_idx), .rd_bad(rd_bad), .bad_count(bad_count),
    .done(done), .blk0_warn(blk0_warn)
  );

  function automatic logic [7:0] marker(int pat, int b, int pg);
    if (pat == 0) begin
      if (pg == 0 && b % 5 == 3) return 8'h00;
      if (pg == 1 && b % 7 == 2) return 8'hFE;
    end else begin
      if (pg == 0 && (b == 0 || b % 4 == 1)) return 8'h7F;
      if (pg == 1 && (b == NB - 1 || b % 3 == 0)) return 8'hEF;
    end
    return 8'hFF;
  endfunction

  function automatic bit exp_bad(int pat, int b);
    return marker(pat, b, 0) != 8'hFF || marker(pat, b, 1) != 8'hFF;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // read engine model and start driver
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      start = 0;
      if (rsp_fire) begin
        rsp_valid = 0; rsp_fire = 0; pending = 0;
      end
      if (go && !pending) begin
        start = 1; go = 0; req_ready = 0;
        exp_blk = 0; exp_page = 0; nreq = 0;
      end else if (!pending) begin
        req_ready = (cyc % 3 != 0);
        if (req_valid && req_ready) begin
          chk(req_row == RW'(exp_blk * PG + exp_page), "R1 row", int'(req_row), exp_blk * PG + exp_page);
          chk(req_col == 4'd5, "R1 col", int'(req_col), 5);
          chk(done == 0, "R5 request while done", int'(done), 0);
          pending = 1; lat = cyc % 4; nreq++;
        end
      end else begin
        req_ready = 0;
      end
      if (pending && !rsp_fire) begin
        if (lat > 0) lat--;
        else begin
          rsp_valid = 1;
          rsp_data = marker(cur_pat, exp_blk, exp_page);
          if (rsp_ready) begin
            rsp_fire = 1;
            if (exp_page == 0 && rsp_data == 8'hFF) exp_page = 1;
            else begin exp_blk++; exp_page = 0; end
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  task automatic kick(int pat);
    cur_pat = pat;
    go = 1;
    wait (go == 0);
    @(negedge clk);
    chk(done == 0, "R6 done cleared by start", int'(done), 0);
    chk(bad_count == 0, "R6 count cleared by start", int'(bad_count), 0);
    chk(blk0_warn == 0, "R6 warn cleared by start", int'(blk0_warn), 0);
  endtask

  task automatic verify(int pat);
    int ecnt = 0, ereq = 0;
    wait (done);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      rd_idx = BW'(b);
      #1;
      chk(rd_bad == exp_bad(pat, b), "R2 table bit", int'(rd_bad), int'(exp_bad(pat, b)));
      if (exp_bad(pat, b)) ecnt++;
      ereq += (marker(pat, b, 0) != 8'hFF) ? 1 : 2;
    end
    chk(bad_count == CW'(ecnt), "R4 bad count", int'(bad_count), ecnt);
    chk(nreq == ereq, "R3 request count", nreq, ereq);
    chk(blk0_warn == exp_bad(pat, 0), "R7 block0 warning", int'(blk0_warn), int'(exp_bad(pat, 0)));
    repeat (20) @(negedge clk);
    chk(done == 1, "R5 done holds", int'(done), 1);
    chk(req_valid == 0, "R5 idle after done", int'(req_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0, "R9 reset done", int'(done), 0);
    chk(bad_count == 0, "R9 reset count", int'(bad_count), 0);
    chk(req_valid == 0, "R9 reset request", int'(req_valid), 0);
    chk(blk0_warn == 0, "R9 reset warn", int'(blk0_warn), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(req_valid == 0 && done == 0, "R9 idle before start", int'(req_valid), 0);

    kick(0);
    verify(0);
    kick(1);
    verify(1);

    // R6: restart in the middle of a scan
    kick(1);
    wait (exp_blk >= 5);
    chk(done == 0, "R5 done low mid-scan", int'(done), 0);
    kick(0);
    verify(0);

    finished = 1;
    finish_run();
  end
endmodule